// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer with Low-Power Wake

This block is the control sequencer that a small 16-bit CPU core uses to get into and out of interrupt handlers. It owns the program counter, the status word and the stack pointer. When an interrupt request arrives and the global enable bit of the status word is set, it saves the program counter and then the status word to a downward-growing stack. It clears the global enable bit and the low-power mode bits, fetches the handler address from a vector table, and loads that address into the program counter. A request that arrives while the core is stopped in low power wakes it the same way.

A return command from the instruction decoder makes the sequencer restore the status word and then the program counter from the stack. If the restored status word still has its CPU-off bit set, the core goes straight back to sleep and executes nothing at the restored address. If the handler cleared that bit in the stacked copy, execution continues in active mode. Outside a sequence, the datapath may write the program counter and status word directly. The instruction decoder and the datapath themselves are not part of this block.

Top module: `irq_seq`

## Requirements
- R1: After reset the program counter equals RST_PC (default 0xC000), the status word is 0, the stack pointer equals SP_INIT (default 0x0400), busy and sleep are low, and no memory request is made.
- R2: An interrupt request is accepted only while the sequencer is idle and status bit 3 (global enable) is set; with that bit clear, the request causes no memory access and leaves all registers unchanged.
- R3: On acceptance, the program counter is written to address SP-2 and then the status word to address SP-4, each in its own cycle, with the values held at acceptance; the stack pointer ends 4 lower.
- R4: After the status word is saved, bits 3 (global enable), 4 (CPU off), 5 (oscillator off) and 7 (system clock generator 1 off) of the status word are cleared and all other bits are kept.
- R5: The handler address is read as one 16-bit word at VEC_BASE + 2*index (default VEC_BASE 0xFFE0) and loaded into the program counter; busy is high for exactly three cycles, from the cycle after acceptance to the vector fetch.
- R6: A return command pops the status word from address SP and then the program counter from SP+2, in two cycles, and raises the stack pointer by 4.
- R7: sleep is high whenever the sequencer is idle and status bit 4 is set; while asleep a return command is ignored, and an enabled interrupt request wakes the core through the normal entry.
- R8: When a return command and an interrupt request arrive in the same idle cycle, the return runs first; the interrupt is then taken only if the restored status word has its global enable bit set.
- R9: Direct writes to the program counter and status word take effect only in idle cycles that start no sequence; they are ignored during a sequence and in the cycle it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_req | input | 1 | Interrupt request level |
| irq_idx | input | IDX_W | Index of the requesting source, selects the vector word |
| reti_cmd | input | 1 | Return-from-interrupt command from the decoder |
| pc_we | input | 1 | Datapath write enable for the program counter |
| pc_wdata | input | 16 | Datapath value for the program counter |
| sr_we | input | 1 | Datapath write enable for the status word |
| sr_wdata | input | 16 | Datapath value for the status word |
| mem_req | output | 1 | Stack or vector memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Byte address of the word accessed |
| mem_wdata | output | 16 | Word written |
| mem_rdata | input | 16 | Word read, valid in the cycle of the access |
| pc | output | 16 | Program counter |
| sr | output | 16 | Status word |
| sp | output | 16 | Stack pointer |
| busy | output | 1 | Entry or return sequence in progress |
| sleep | output | 1 | Core stopped in low power |

## Verification
A return command and an interrupt request can land in the same idle cycle. The bench raises both on one clock edge and keeps the request high until well after the return has finished. It runs this case twice: once with a stacked status word whose global enable bit is clear, where the bench expects only the restored program counter and stack pointer and no entry, and once with that bit set, where it expects the restore, one idle cycle, then a full entry that pushes the just-restored program counter and status word. The push order and values are read from a log of the memory writes.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;

    localparam int W = 16;

    // status word bit positions
    localparam int B_GIE    = 3;
    localparam int B_CPUOFF = 4;
    localparam int B_OSCOFF = 5;
    localparam int B_SCG0   = 6;
    localparam int B_SCG1   = 7;

    // bits cleared once the status word has been saved
    localparam logic [W-1:0] ENTRY_CLR = W'((1 << B_GIE) | (1 << B_CPUOFF) |
                                            (1 << B_OSCOFF) | (1 << B_SCG1));

    localparam logic [W-1:0] WORD_BYTES = W'(2);

    typedef enum logic [2:0] {
        S_IDLE,
        S_PUSH_PC,
        S_PUSH_SR,
        S_VEC,
        S_POP_SR,
        S_POP_PC
    } seq_st_e;

endpackage

// File: rtl/irq_seq_arb.sv
module irq_seq_arb (
    input  logic idle,
    input  logic sleeping,
    input  logic gie,
    input  logic irq_req,
    input  logic reti_cmd,
    output logic take_ret,
    output logic take_irq
);
    // a return that is asked for in the same cycle wins; the interrupt is
    // reconsidered once the restored status word is in place
    always_comb begin
        take_ret = idle && reti_cmd && !sleeping;
        take_irq = idle && irq_req && gie && !take_ret;
    end
endmodule

// File: rtl/irq_seq_vec.sv
module irq_seq_vec #(
    parameter int          IDX_W    = 4,
    parameter logic [15:0] VEC_BASE = 16'hFFE0
) (
    input  logic [IDX_W-1:0] idx,
    output logic [15:0]      addr
);
    localparam int SHIFT = 1;  // one 16-bit word per source

    always_comb begin
        addr = VEC_BASE + (16'(idx) << SHIFT);
    end
endmodule

// File: rtl/irq_seq.sv
module irq_seq #(
    parameter int          IDX_W    = 4,
    parameter logic [15:0] VEC_BASE = 16'hFFE0,
    parameter logic [15:0] SP_INIT  = 16'h0400,
    parameter logic [15:0] RST_PC   = 16'hC000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_req,
    input  logic [IDX_W-1:0] irq_idx,
    input  logic             reti_cmd,
    input  logic             pc_we,
    input  logic [15:0]      pc_wdata,
    input  logic             sr_we,
    input  logic [15:0]      sr_wdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic [15:0]      mem_addr,
    output logic [15:0]      mem_wdata,
    input  logic [15:0]      mem_rdata,
    output logic [15:0]      pc,
    output logic [15:0]      sr,
    output logic [15:0]      sp,
    output logic             busy,
    output logic             sleep
);
    import irq_seq_pkg::*;

    typedef struct packed {
        seq_st_e          st;
        logic [W-1:0]     pc;
        logic [W-1:0]     sr;
        logic [W-1:0]     sp;
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t         r_q, r_d;
    logic         idle;
    logic         take_ret, take_irq;
    logic [W-1:0] vec_addr;

    assign idle = (r_q.st == S_IDLE);

    irq_seq_arb u_arb (
        .idle     (idle),
        .sleeping (r_q.sr[B_CPUOFF]),
        .gie      (r_q.sr[B_GIE]),
        .irq_req  (irq_req),
        .reti_cmd (reti_cmd),
        .take_ret (take_ret),
        .take_irq (take_irq)
    );

    irq_seq_vec #(
        .IDX_W    (IDX_W),
        .VEC_BASE (VEC_BASE)
    ) u_vec (
        .idx  (r_q.idx),
        .addr (vec_addr)
    );

    always_comb begin
        r_d       = r_q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (r_q.st)
            S_IDLE: begin
                if (take_ret) begin
                    r_d.st = S_POP_SR;
                end else if (take_irq) begin
                    r_d.st  = S_PUSH_PC;
                    r_d.idx = irq_idx;
                end else begin
                    if (pc_we) r_d.pc = pc_wdata;
                    if (sr_we) r_d.sr = sr_wdata;
                end
            end
            S_PUSH_PC: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_q.sp - WORD_BYTES;
                mem_wdata = r_q.pc;
                r_d.sp    = r_q.sp - WORD_BYTES;
                r_d.st    = S_PUSH_SR;
            end
            S_PUSH_SR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = r_q.sp - WORD_BYTES;
                mem_wdata = r_q.sr;
                r_d.sp    = r_q.sp - WORD_BYTES;
                r_d.sr    = r_q.sr & ~ENTRY_CLR;
                r_d.st    = S_VEC;
            end
            S_VEC: begin
                mem_req  = 1'b1;
                mem_addr = vec_addr;
                r_d.pc   = mem_rdata;
                r_d.st   = S_IDLE;
            end
            S_POP_SR: begin
                mem_req  = 1'b1;
                mem_addr = r_q.sp;
                r_d.sr   = mem_rdata;
                r_d.sp   = r_q.sp + WORD_BYTES;
                r_d.st   = S_POP_PC;
            end
            S_POP_PC: begin
                mem_req  = 1'b1;
                mem_addr = r_q.sp;
                r_d.pc   = mem_rdata;
                r_d.sp   = r_q.sp + WORD_BYTES;
                r_d.st   = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= S_IDLE;
            r_q.pc  <= RST_PC;
            r_q.sr  <= '0;
            r_q.sp  <= SP_INIT;
            r_q.idx <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign pc    = r_q.pc;
    assign sr    = r_q.sr;
    assign sp    = r_q.sp;
    assign busy  = !idle;
    assign sleep = idle && r_q.sr[B_CPUOFF];

    // R2: with the global enable clear and no return asked, nothing starts
    p_gie_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && !r_q.sr[B_GIE] && !reti_cmd) |=> (r_q.st == S_IDLE));

    // R3: the program counter push moves the stack pointer down one word
    p_push_sp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_PUSH_PC) |=> (r_q.st == S_PUSH_SR && r_q.sp == $past(r_q.sp) - 16'd2));

    // R4: mode and enable bits are clear once the status word is saved
    p_mode_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_PUSH_SR) |=> ((r_q.sr & ENTRY_CLR) == '0));

    // R5: the vector word becomes the program counter and the sequence ends
    p_vec_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_VEC) |=> (r_q.pc == $past(mem_rdata) && !busy));

    // R6: the first pop restores the status word from memory
    p_pop_sr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == S_POP_SR) |=> (r_q.sr == $past(mem_rdata)));

    // R7: a sleeping core without a request stays out of any sequence
    p_sleep_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep && !irq_req) |=> !busy);

    // R8: a return asked for in an awake idle cycle always goes first
    p_ret_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (idle && reti_cmd && !sleep) |=> (r_q.st == S_POP_SR));

endmodule

// File: tb/irq_seq_bench.sv
module irq_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_req = 1'b0;
    logic [3:0]  irq_idx = '0;
    logic        reti_cmd = 1'b0;
    logic        pc_we = 1'b0;
    logic [15:0] pc_wdata = '0;
    logic        sr_we = 1'b0;
    logic [15:0] sr_wdata = '0;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic [15:0] pc, sr, sp;
    logic        busy, sleep;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    logic [15:0] m [logic [15:0]];
    logic [15:0] wa [0:15];
    logic [15:0] wd [0:15];
    int          wn = 0;

    always #4 clk = ~clk;

    irq_seq u_irq_seq (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_idx(irq_idx),
        .reti_cmd(reti_cmd), .pc_we(pc_we), .pc_wdata(pc_wdata),
        .sr_we(sr_we), .sr_wdata(sr_wdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .pc(pc), .sr(sr), .sp(sp), .busy(busy), .sleep(sleep)
    );

    // stack and vector memory model with a write log
    always @(posedge clk) begin
        if (mem_req && mem_we) begin
            m[mem_addr] = mem_wdata;
            if (wn < 16) begin
                wa[wn] = mem_addr;
                wd[wn] = mem_wdata;
            end
            wn = wn + 1;
        end
    end

    always @(negedge clk) begin
        mem_rdata = m.exists(mem_addr) ? m[mem_addr] : 16'h0000;
    end

    task automatic chk(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 20) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        chk("R1", "pc", pc, 16'hC000);
        chk("R1", "sr", sr, 16'h0000);
        chk("R1", "sp", sp, 16'h0400);
        chk("R1", "busy/sleep/req", {13'd0, busy, sleep, mem_req}, 16'h0000);
    endtask

    task automatic t_masked;
        wn = 0;
        irq_req = 1'b1;
        irq_idx = 4'd3;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R2", "busy while masked", {15'd0, busy}, 16'h0000);
        end
        irq_req = 1'b0;
        chk("R2", "pc while masked", pc, 16'hC000);
        chk("R2", "writes while masked", 16'(wn), 16'h0000);
        pc_we = 1'b1; pc_wdata = 16'hC100;
        sr_we = 1'b1; sr_wdata = 16'h00F8;
        @(negedge clk);
        pc_we = 1'b0; sr_we = 1'b0;
        chk("R9", "idle pc write", pc, 16'hC100);
        chk("R7", "sleep with cpu-off", {15'd0, sleep}, 16'h0001);
    endtask

    task automatic t_entry;
        int n;
        m[16'hFFEA] = 16'hD050;
        wn = 0;
        irq_req = 1'b1; irq_idx = 4'd5;
        pc_we = 1'b1; pc_wdata = 16'hBEEF;
        sr_we = 1'b1; sr_wdata = 16'hFFFF;
        @(negedge clk);
        irq_req = 1'b0;
        chk("R7", "wake starts entry", {15'd0, busy}, 16'h0001);
        wait_idle(n);
        pc_we = 1'b0; sr_we = 1'b0;
        chk("R5", "busy cycles", 16'(n), 16'd3);
        chk("R5", "pc from vector", pc, 16'hD050);
        chk("R3", "sp after push", sp, 16'h03FC);
        chk("R4", "sr after entry", sr, 16'h0040);
        chk("R3", "first push addr", wa[0], 16'h03FE);
        chk("R3", "first push pc", wd[0], 16'hC100);
        chk("R3", "second push addr", wa[1], 16'h03FC);
        chk("R3", "second push sr", wd[1], 16'h00F8);
        chk("R9", "core writes during entry", 16'(wn), 16'd2);
        chk("R7", "awake after entry", {15'd0, sleep}, 16'h0000);
    endtask

    task automatic t_return_sleep;
        int n;
        reti_cmd = 1'b1;
        @(negedge clk);
        reti_cmd = 1'b0;
        wait_idle(n);
        chk("R6", "pop cycles", 16'(n), 16'd2);
        chk("R6", "sr restored", sr, 16'h00F8);
        chk("R6", "pc restored", pc, 16'hC100);
        chk("R6", "sp after pop", sp, 16'h0400);
        chk("R7", "back to sleep", {15'd0, sleep}, 16'h0001);
        reti_cmd = 1'b1;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk("R7", "return while asleep", {15'd0, busy}, 16'h0000);
        end
        reti_cmd = 1'b0;
        chk("R7", "sp kept while asleep", sp, 16'h0400);
    endtask

    task automatic t_return_active;
        int n;
        m[16'hFFE4] = 16'hD200;
        irq_req = 1'b1; irq_idx = 4'd2;
        @(negedge clk);
        irq_req = 1'b0;
        wait_idle(n);
        chk("R5", "second vector", pc, 16'hD200);
        m[16'h03FC] = 16'h0008;   // handler clears the mode bits in the stacked copy
        reti_cmd = 1'b1;
        @(negedge clk);
        reti_cmd = 1'b0;
        wait_idle(n);
        chk("R6", "active sr", sr, 16'h0008);
        chk("R6", "active pc", pc, 16'hC100);
        chk("R7", "no sleep after active return", {15'd0, sleep}, 16'h0000);
    endtask

    task automatic t_collide;
        m[16'h0400] = 16'h0000;
        m[16'h0402] = 16'hC300;
        m[16'hFFE2] = 16'hD100;
        reti_cmd = 1'b1; irq_req = 1'b1; irq_idx = 4'd1;
        @(negedge clk);
        reti_cmd = 1'b0;
        for (int i = 0; i < 5; i++) @(negedge clk);
        chk("R8", "no entry with restored enable clear", {15'd0, busy}, 16'h0000);
        chk("R8", "pc restored, no entry", pc, 16'hC300);
        chk("R8", "sp after plain return", sp, 16'h0404);
        irq_req = 1'b0;
        @(negedge clk);

        m[16'h0404] = 16'h0008;
        m[16'h0406] = 16'hC400;
        wn = 0;
        reti_cmd = 1'b1; irq_req = 1'b1;
        @(negedge clk);
        reti_cmd = 1'b0;
        for (int i = 0; i < 3; i++) @(negedge clk);
        chk("R8", "entry follows return", {15'd0, busy}, 16'h0001);
        irq_req = 1'b0;
        for (int i = 0; i < 3; i++) @(negedge clk);
        chk("R8", "pc after return then entry", pc, 16'hD100);
        chk("R8", "sp after return then entry", sp, 16'h0404);
        chk("R8", "sr after return then entry", sr, 16'h0000);
        chk("R8", "pushed restored pc", wd[0], 16'hC400);
        chk("R8", "pushed restored sr", wd[1], 16'h0008);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<20000 cycles", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_masked();
        t_entry();
        t_return_sleep();
        t_return_active();
        t_collide();
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule